// File: doc/BRIEF.md
# Event-Triggered Countdown Timer

This block is an 8-bit down-counter paced by a power-of-two prescaler running from the chip clock. It times intervals around radio frames. A host strobe or selected transmitter frame events start it. A host strobe or selected receiver frame events stop it. When a tick finds the count at zero, the timer expires and raises a one-cycle interrupt pulse. It then either goes idle or reloads itself and carries on.

A start loads the reload value into the counter and clears the prescaler. Each prescaled tick then takes one from the count. A stop freezes the count where it is and raises no interrupt, so the host can read back how much time was left.

The control is a small state machine with two states:
- `ST_IDLE`: the counter holds its value.
- `ST_RUN`: the counter consumes ticks.

Its transitions are:
- `T_START` (idle to run): an accepted start.
- `T_STOP` (run to idle): an accepted stop.
- `T_EXPIRE` (run to idle): expiry with auto-reload off.
- `T_RELOAD` (run to run): expiry with auto-reload on.
- `T_RESTART` (run to run): a start while already running, which reloads the count.

Top module: `evtimer_top`

## Requirements
- R1: When `start_now_i` is high at a clock edge (and no stop is accepted), after that edge `running_o` is 1 and `count_o` equals `reload_i`.
- R2: While running, the count drops by one every 2^`prescale_i` clock cycles. The first drop comes 2^`prescale_i` edges after the start edge; with `prescale_i`=0 it drops on every edge.
- R3: `tx_begin_i` starts the timer only when `trig_en_i[0]` is 1, and `tx_end_i` only when `trig_en_i[1]` is 1. Otherwise these events are ignored.
- R4: `stop_now_i` always stops the timer. `rx_begin_i` stops it only when `trig_en_i[2]` is 1, and `rx_end_i` only when `trig_en_i[3]` is 1. A stop clears `running_o`, freezes `count_o` and raises no interrupt. Disabled receive events are ignored.
- R5: A tick that finds the count at 0 while running is an expiry. `expire_irq_o` is high for exactly the one cycle after that edge. With `auto_reload_i`=0, `running_o` clears and the count stays 0. Expiry therefore comes (reload+1)·2^`prescale_i` edges after the start edge.
- R6: With `auto_reload_i`=1, an expiry reloads `reload_i` and the timer keeps running. An interrupt pulse follows every (reload+1)·2^`prescale_i` edges.
- R7: When a start and a stop are accepted at the same edge, the stop wins. A start while running reloads the count and cancels the pending expiry.
- R8: After reset, `count_o`=0, `running_o`=0 and `expire_irq_o`=0.
- R9: While idle and not started, `count_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Chip clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reload_i | input | 8 | Value loaded into the counter at start and at auto-reload |
| prescale_i | input | 5 | Tick period is 2^prescale_i clocks |
| trig_en_i | input | 4 | Event enables: [0] start on tx begin, [1] start on tx end, [2] stop on rx begin, [3] stop on rx end |
| auto_reload_i | input | 1 | Reload and keep running after expiry |
| start_now_i | input | 1 | Host start strobe |
| stop_now_i | input | 1 | Host stop strobe |
| tx_begin_i | input | 1 | Transmit frame begin event pulse |
| tx_end_i | input | 1 | Transmit frame end event pulse |
| rx_begin_i | input | 1 | Receive frame begin event pulse |
| rx_end_i | input | 1 | Receive frame end event pulse |
| count_o | output | 8 | Current count |
| running_o | output | 1 | Timer active |
| expire_irq_o | output | 1 | One-cycle expiry interrupt pulse |

## Verification
Every result is registered, so a start or stop shows on `running_o` and `count_o` one edge after the strobe is sampled. The count's first drop is due 2^`prescale_i` edges after the start edge. The expiry pulse is due (reload+1)·2^`prescale_i` edges after it. The driver tags each strobe with the number of the edge that samples it, and pushes the edge number at which each interrupt is due into a queue. A monitor sampling on the falling clock pops one entry per observed pulse and compares the cycle. Any pulse with no entry is reported as unexpected, and so is an entry left unconsumed at the end. Count and running checks are also taken on the falling clock, at cycle numbers derived from the same formulas.

// File: rtl/evtimer_pkg.sv
package evtimer_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_e;

    // bit positions inside the event-enable vector
    localparam int EN_START_TXB = 0;
    localparam int EN_START_TXE = 1;
    localparam int EN_STOP_RXB  = 2;
    localparam int EN_STOP_RXE  = 3;
    localparam int EN_W         = 4;
endpackage

// File: rtl/evtimer_trigsel.sv
module evtimer_trigsel
    import evtimer_pkg::*;
(
    input  logic [EN_W-1:0] trig_en_i,
    input  logic            start_now_i,
    input  logic            stop_now_i,
    input  logic            tx_begin_i,
    input  logic            tx_end_i,
    input  logic            rx_begin_i,
    input  logic            rx_end_i,
    output logic            start_hit_o,
    output logic            stop_hit_o
);
    localparam int NSRC = 3;

    logic [NSRC-1:0] start_src;
    logic [NSRC-1:0] stop_src;

    // source 0 is the host strobe, sources 1..2 are gated frame events (R3, R4)
    always_comb begin
        start_src[0] = start_now_i;
        start_src[1] = tx_begin_i & trig_en_i[EN_START_TXB];
        start_src[2] = tx_end_i   & trig_en_i[EN_START_TXE];
        stop_src[0]  = stop_now_i;
        stop_src[1]  = rx_begin_i & trig_en_i[EN_STOP_RXB];
        stop_src[2]  = rx_end_i   & trig_en_i[EN_STOP_RXE];
    end

    assign start_hit_o = |start_src;
    assign stop_hit_o  = |stop_src;
endmodule

// File: rtl/evtimer_prescale.sv
module evtimer_prescale #(
    parameter int PRE_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic [PRE_W-1:0] sel_i,
    output logic             tick_o
);
    // wide enough to hold 2^(2^PRE_W - 1) - 1
    localparam int CW = (1 << PRE_W) - 1;

    logic [CW-1:0] pre_q;
    logic [CW-1:0] lim;

    // divide by 2^sel; at the top setting the shift wraps to zero and the limit becomes all ones
    always_comb lim = (CW'(1) << sel_i) - CW'(1);

    assign tick_o = en_i && (pre_q == lim);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pre_q <= '0;
        end else if (!en_i || clr_i) begin
            pre_q <= '0;
        end else if (tick_o) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + CW'(1);
        end
    end

    // after a tick the phase restarts, so two ticks in a row need sel = 0
    assert_tick_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && $past(en_i) && $past(tick_o) && (sel_i != '0)) |-> !tick_o);
endmodule

// File: rtl/evtimer_fsm.sv
module evtimer_fsm
    import evtimer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_hit_i,
    input  logic             stop_hit_i,
    input  logic             tick_i,
    input  logic             auto_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic             irq_o
);
    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic             irq_q;
    logic             expire;

    assign expire = (state_q == ST_RUN) && tick_i && (count_q == '0);

    // next-state logic: stop > start > expiry (R7)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!stop_hit_i && start_hit_i) state_d = ST_RUN;     // T_START
            end
            ST_RUN: begin
                if (stop_hit_i)                 state_d = ST_IDLE;    // T_STOP
                else if (start_hit_i)           state_d = ST_RUN;     // T_RESTART
                else if (expire && !auto_i)     state_d = ST_IDLE;    // T_EXPIRE
                else                            state_d = ST_RUN;     // T_RELOAD or counting
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // registered outputs: count and interrupt pulse
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            count_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (stop_hit_i) begin
                count_q <= count_q;
            end else if (start_hit_i) begin
                count_q <= reload_i;
            end else if (state_q == ST_RUN && tick_i) begin
                if (expire) begin
                    irq_q <= 1'b1;
                    if (auto_i) count_q <= reload_i;
                end else begin
                    count_q <= count_q - CNT_W'(1);
                end
            end
        end
    end

    assign count_o   = count_q;
    assign running_o = (state_q == ST_RUN);
    assign irq_o     = irq_q;

    assert_start_loads_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_hit_i && !stop_hit_i) |=> (running_o && count_o == $past(reload_i)));

    assert_stop_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_hit_i |=> (!running_o && !irq_o && $stable(count_o)));

    assert_decrement_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running_o && tick_i && !start_hit_i && !stop_hit_i && count_o != '0)
        |=> count_o == $past(count_o) - CNT_W'(1));

    assert_irq_origin_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ($past(running_o) && $past(tick_i) && $past(count_o) == '0));

    assert_irq_running_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (running_o == $past(auto_i)));

    assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!running_o && !start_hit_i) |=> $stable(count_o));
endmodule

// File: rtl/evtimer_top.sv
module evtimer_top
    import evtimer_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PRE_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [PRE_W-1:0] prescale_i,
    input  logic [EN_W-1:0]  trig_en_i,
    input  logic             auto_reload_i,
    input  logic             start_now_i,
    input  logic             stop_now_i,
    input  logic             tx_begin_i,
    input  logic             tx_end_i,
    input  logic             rx_begin_i,
    input  logic             rx_end_i,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic             expire_irq_o
);
    logic start_hit, stop_hit, tick;

    evtimer_trigsel u_trig (
        .trig_en_i   (trig_en_i),
        .start_now_i (start_now_i),
        .stop_now_i  (stop_now_i),
        .tx_begin_i  (tx_begin_i),
        .tx_end_i    (tx_end_i),
        .rx_begin_i  (rx_begin_i),
        .rx_end_i    (rx_end_i),
        .start_hit_o (start_hit),
        .stop_hit_o  (stop_hit)
    );

    evtimer_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (running_o),
        .clr_i  (start_hit),
        .sel_i  (prescale_i),
        .tick_o (tick)
    );

    evtimer_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_hit_i (start_hit),
        .stop_hit_i  (stop_hit),
        .tick_i      (tick),
        .auto_i      (auto_reload_i),
        .reload_i    (reload_i),
        .count_o     (count_o),
        .running_o   (running_o),
        .irq_o       (expire_irq_o)
    );
endmodule

// File: tb/tb_evtimer_top.sv
module tb_evtimer_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reload = '0;
    logic [4:0] presc = '0;
    logic [3:0] ten = '0;
    logic       autor = 1'b0;
    logic       s_now = 1'b0, p_now = 1'b0, txb = 1'b0, txe = 1'b0, rxb = 1'b0, rxe = 1'b0;
    logic [7:0] count;
    logic       running, irq;

    int ntest = 0, nfail = 0, cyc = 0;
    int exp_q[$];
    bit done = 1'b0;

    localparam int K_START = 0, K_STOP = 1, K_TXB = 2, K_TXE = 3, K_RXB = 4, K_RXE = 5, K_BOTH = 6;

    evtimer_top dut (
        .clk_i(clk), .rst_ni(rst_n), .reload_i(reload), .prescale_i(presc),
        .trig_en_i(ten), .auto_reload_i(autor), .start_now_i(s_now), .stop_now_i(p_now),
        .tx_begin_i(txb), .tx_end_i(txe), .rx_begin_i(rxb), .rx_end_i(rxe),
        .count_o(count), .running_o(running), .expire_irq_o(irq)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        ntest++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: cycle %0d actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // drive a strobe at the current falling edge; returns the edge number that samples it
    task automatic strobe(input int kind, output int edge_no);
        case (kind)
            K_START: s_now = 1'b1;
            K_STOP:  p_now = 1'b1;
            K_TXB:   txb = 1'b1;
            K_TXE:   txe = 1'b1;
            K_RXB:   rxb = 1'b1;
            K_RXE:   rxe = 1'b1;
            default: begin s_now = 1'b1; p_now = 1'b1; end
        endcase
        edge_no = cyc + 1;
        @(negedge clk);
        {s_now, p_now, txb, txe, rxb, rxe} = '0;
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // monitor: every expiry pulse must match the next scheduled cycle (R5, R6)
    int mon_e;
    always @(negedge clk) begin
        if (rst_n && irq && !done) begin
            ntest++;
            if (exp_q.size() == 0) begin
                nfail++;
                $display("FAIL R5: unexpected expiry pulse at cycle %0d (actual 1, expected 0)", cyc);
            end else begin
                mon_e = exp_q.pop_front();
                if (mon_e != cyc) begin
                    nfail++;
                    $display("FAIL R5/R6: expiry pulse at cycle %0d, expected %0d", cyc, mon_e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", ntest, nfail);
        $finish;
    end

    initial begin
        int b, s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk("R8 count", count, 0);
        chk("R8 running", running, 0);
        chk("R8 irq", irq, 0);

        // R1/R2/R5: start_now, divide by 1
        reload = 8'd5; presc = 5'd0;
        strobe(K_START, b); exp_q.push_back(b + 6);
        chk("R1 running after start", running, 1);
        chk("R1 count loaded", count, 5);
        wait_until(b + 2);
        chk("R2 count after 2 ticks", count, 3);
        wait_until(b + 8);
        chk("R5 running cleared", running, 0);
        chk("R5 count stays 0", count, 0);
        wait_until(b + 11);
        chk("R9 idle count held", count, 0);

        // R2: divide by 4
        reload = 8'd3; presc = 5'd2;
        strobe(K_START, b); exp_q.push_back(b + 16);
        wait_until(b + 3);
        chk("R2 no drop before period", count, 3);
        wait_until(b + 4);
        chk("R2 drop at period", count, 2);
        wait_until(b + 18);
        chk("R5 idle after prescaled expiry", running, 0);

        // R3: transmit events gated by enables
        reload = 8'd4; presc = 5'd0; ten = 4'b0000;
        strobe(K_TXB, b); wait_until(b + 2);
        chk("R3 tx begin ignored when disabled", running, 0);
        ten = 4'b0001;
        strobe(K_TXE, b); wait_until(b + 2);
        chk("R3 tx end ignored with only bit0", running, 0);
        strobe(K_TXB, b); exp_q.push_back(b + 5);
        chk("R3 tx begin starts", running, 1);
        wait_until(b + 7);
        ten = 4'b0010;
        strobe(K_TXE, b); exp_q.push_back(b + 5);
        chk("R3 tx end starts", running, 1);
        wait_until(b + 7);

        // R4: stop_now freezes count, no interrupt
        reload = 8'd10; ten = 4'b0000;
        strobe(K_START, b); wait_until(b + 3);
        strobe(K_STOP, s);
        chk("R4 stop_now clears running", running, 0);
        chk("R4 stop_now freezes count", count, 7);
        wait_until(b + 20);
        chk("R4 count held after stop", count, 7);

        // R4: rx begin stop when enabled, ignored otherwise
        ten = 4'b0100;
        strobe(K_START, b); wait_until(b + 2);
        strobe(K_RXB, s);
        chk("R4 rx begin stops", running, 0);
        chk("R4 rx begin count frozen", count, 8);
        ten = 4'b0000;
        strobe(K_START, b); exp_q.push_back(b + 11);
        wait_until(b + 2);
        strobe(K_RXB, s);
        chk("R4 rx begin ignored when disabled", running, 1);
        strobe(K_RXE, s);
        chk("R4 rx end ignored when disabled", running, 1);
        wait_until(b + 13);

        // R4: rx end stop
        ten = 4'b1000;
        strobe(K_START, b); wait_until(b + 4);
        strobe(K_RXE, s);
        chk("R4 rx end stops", running, 0);
        chk("R4 rx end count frozen", count, 6);
        ten = 4'b0000;

        // R6: auto-reload
        reload = 8'd2; autor = 1'b1;
        strobe(K_START, b);
        exp_q.push_back(b + 3); exp_q.push_back(b + 6); exp_q.push_back(b + 9);
        wait_until(b + 10);
        chk("R6 still running after reloads", running, 1);
        chk("R6 count after reload", count, 1);
        strobe(K_STOP, s);
        autor = 1'b0;
        chk("R6 stopped", running, 0);
        wait_until(s + 6);

        // R7: start and stop together, stop wins
        strobe(K_BOTH, s);
        chk("R7 stop beats start", running, 0);

        // R7: restart while running reloads
        reload = 8'd6;
        strobe(K_START, b); wait_until(b + 3);
        strobe(K_START, s); exp_q.push_back(s + 7);
        chk("R7 restart reloads", count, 6);
        wait_until(s + 9);

        // R5: reload of zero expires after one period (divide by 2)
        reload = 8'd0; presc = 5'd1;
        strobe(K_START, b); exp_q.push_back(b + 2);
        wait_until(b + 4);
        chk("R5 zero reload idle", running, 0);

        wait_until(cyc + 4);
        done = 1'b1;
        chk("R5 all scheduled expiries seen", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", ntest, nfail);
        $finish;
    end
endmodule